// File: doc/BRIEF.md
# Half-Word Write Packer for a Transmit FIFO

This block sits between a memory-mapped slave port and the push side of a 16-bit wide FIFO. Every write beat that lands in its address window is turned into one or more FIFO entries, according to its width. A half-word write makes one entry. A word write makes two entries, low half first. Byte writes are paired: a byte written to an odd address is parked in a holding register, and the following even-address byte pushes both as one entry. Reads inside or outside the window are accepted at once and return zero.

Flow control uses a valid/ready handshake on both sides. The bus master holds a beat stable until `bus_ready` is high. The FIFO reports free space on `push_ready`. When the FIFO is full, the beat is stalled until every entry it produces has been taken. The push and the bus acceptance are produced combinationally in the cycle the beat is presented, so the block adds no latency when the FIFO has room.

Top module: `wr_pack_adapter`

## Requirements
- R1: A beat whose address bits from WIN_LSB upward differ from those of WIN_BASE is accepted in the cycle it is presented, produces no push and leaves the held byte and word sequence untouched.
- R2: A half-word write (size code 1) produces exactly one push carrying wdata[31:16] when addr[1] is 1, otherwise wdata[15:0].
- R3: A word write (size code 2) pushes wdata[15:0] first and wdata[31:16] in a later cycle; bus_ready is low during the first push and is high only in the cycle the second push is accepted.
- R4: A byte write (size code 0) to an odd address produces no push, is accepted in the same cycle and stores the byte from lane addr[1:0] of wdata (bits 8*addr[1:0]+7 down to 8*addr[1:0]).
- R5: A byte write to an even address pushes one entry with the even byte in bits [7:0] and the held odd byte in bits [15:8], and the held byte is then marked empty.
- R6: A second odd-address byte write before the even byte replaces the held byte.
- R7: An even-address byte write with no byte held pushes the byte with zero in bits [15:8].
- R8: Reads are accepted in the cycle they are presented, return zero on bus_rdata, make no push and leave the held byte and word sequence unchanged.
- R9: While push_valid is high and push_ready is low, bus_ready is low and push_valid and push_data stay stable until the entry is taken.
- R10: Reset clears the held-byte flag and any half-finished word sequence; after reset push_valid is low and an idle port shows bus_ready high.
- R11: Half-word and word writes leave a held odd byte in place for the next even byte.
- R12: A write with the reserved size code 3 is accepted at once and produces no push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_valid | input | 1 | Beat presented |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the beat |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data, byte lanes by address |
| bus_ready | output | 1 | Beat accepted this cycle |
| bus_rdata | output | 32 | Read data, always zero |
| push_valid | output | 1 | FIFO entry offered |
| push_data | output | 16 | FIFO entry |
| push_ready | input | 1 | FIFO has room |

## Verification
The push, its data and the bus acceptance are all due in the same cycle a beat is presented, while the held byte and the word phase take effect at the following rising edge; the second half of a word is due no earlier than one cycle after the first is taken. The bench therefore drives each cycle's inputs at the falling edge, compares the combinational outputs a moment later against a behavioural model, and only then advances the model state, so each result is compared in exactly the cycle it is due. FIFO back-pressure is drawn at random per cycle so stalls fall on first halves, second halves and paired bytes alike.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int BUS_W   = 32;
  localparam int ENTRY_W = 16;
  localparam int BYTE_W  = 8;
  localparam int LANES   = BUS_W / BYTE_W;
  localparam int HALVES  = BUS_W / ENTRY_W;
  localparam int LANE_SW = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } wp_size_e;

  typedef struct packed {
    logic                 wr;      // write beat inside the window
    wp_size_e             size;
    logic                 odd;     // byte address is odd
    logic [BYTE_W-1:0]    byte_d;  // addressed byte lane
    logic [ENTRY_W-1:0]   half_d;  // addressed half-word lane
    logic [ENTRY_W-1:0]   lo;
    logic [ENTRY_W-1:0]   hi;
  } wp_req_t;

endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_LSB  = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output wp_req_t           req
);

  localparam int TAG_W = ADDR_W - WIN_LSB;

  logic [TAG_W-1:0]   addr_tag;
  logic [TAG_W-1:0]   base_tag;
  logic               win_hit;
  logic [BYTE_W-1:0]  lane  [LANES];
  logic [ENTRY_W-1:0] halfw [HALVES];

  assign addr_tag = bus_addr[ADDR_W-1:WIN_LSB];
  assign base_tag = WIN_BASE[ADDR_W-1:WIN_LSB];
  assign win_hit  = (addr_tag == base_tag);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = bus_wdata[g*BYTE_W +: BYTE_W];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign halfw[h] = bus_wdata[h*ENTRY_W +: ENTRY_W];
  end

  always_comb begin
    req        = '0;
    req.wr     = bus_valid & bus_write & win_hit;
    req.size   = wp_size_e'(bus_size);
    req.odd    = bus_addr[0];
    req.byte_d = lane[bus_addr[LANE_SW-1:0]];
    req.half_d = halfw[bus_addr[1]];
    req.lo     = halfw[0];
    req.hi     = halfw[HALVES-1];
  end

endmodule

// File: rtl/wp_hold.sv
module wp_hold
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              consume,
  input  logic [BYTE_W-1:0] din,
  output logic              held_valid,
  output logic [BYTE_W-1:0] held_byte
);

  logic              hv_q, hv_d, hv_en;
  logic [BYTE_W-1:0] hb_q, hb_d;

  always_comb begin
    hv_d  = hv_q;
    hb_d  = hb_q;
    hv_en = load | consume;
    if (load) begin
      hv_d = 1'b1;
      hb_d = din;
    end else if (consume) begin
      hv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hv_q <= 1'b0;
    else if (hv_en) hv_q <= hv_d;
  end

  // data register carries no reset; it is only read when hv_q is set
  always_ff @(posedge clk) begin
    if (load) hb_q <= hb_d;
  end

  assign held_valid = hv_q;
  assign held_byte  = hb_q;

  // R4, R6: a load leaves the flag set and the newest byte stored
  a_r6_load_keeps_latest: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (hv_q && hb_q == $past(din)));

  // R5: consuming without a new load empties the register
  a_r5_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !load) |=> !hv_q);

endmodule

// File: rtl/wp_seq.sv
module wp_seq
  import wp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  wp_req_t            req,
  input  logic               held_valid,
  input  logic [BYTE_W-1:0]  held_byte,
  input  logic               push_ready,
  output logic               push_valid,
  output logic [ENTRY_W-1:0] push_data,
  output logic               bus_ready,
  output logic               load_odd,
  output logic               consume
);

  logic phase_q, phase_d, phase_en;
  logic [BYTE_W-1:0] upper;

  assign upper = held_valid ? held_byte : '0;

  always_comb begin
    push_valid = 1'b0;
    push_data  = '0;
    bus_ready  = 1'b1;
    load_odd   = 1'b0;
    consume    = 1'b0;
    phase_d    = phase_q;
    if (req.wr) begin
      unique case (req.size)
        SZ_BYTE: begin
          if (req.odd) begin
            load_odd = 1'b1;
          end else begin
            push_valid = 1'b1;
            push_data  = {upper, req.byte_d};
            bus_ready  = push_ready;
            consume    = push_ready;
          end
        end
        SZ_HALF: begin
          push_valid = 1'b1;
          push_data  = req.half_d;
          bus_ready  = push_ready;
        end
        SZ_WORD: begin
          push_valid = 1'b1;
          if (!phase_q) begin
            push_data = req.lo;
            bus_ready = 1'b0;
            if (push_ready) phase_d = 1'b1;
          end else begin
            push_data = req.hi;
            bus_ready = push_ready;
            if (push_ready) phase_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign phase_en = (phase_d != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (phase_en) phase_q <= phase_d;
  end

  // R3: the second half only follows an accepted first half
  a_r3_phase_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q) |-> $past(push_valid && push_ready && !bus_ready));

  // R3: taking the second half releases the beat
  a_r3_phase_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && push_valid && push_ready) |-> bus_ready);

  // R9: a refused entry stalls the bus
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |-> !bus_ready);

endmodule

// File: rtl/wr_pack_adapter.sv
module wr_pack_adapter
  import wp_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_LSB  = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic               bus_ready,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               push_valid,
  output logic [ENTRY_W-1:0] push_data,
  input  logic               push_ready
);

  wp_req_t           req;
  logic              load_odd;
  logic              consume;
  logic              held_valid;
  logic [BYTE_W-1:0] held_byte;

  wp_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_LSB  (WIN_LSB),
    .WIN_BASE (WIN_BASE)
  ) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .req       (req)
  );

  wp_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_odd),
    .consume    (consume),
    .din        (req.byte_d),
    .held_valid (held_valid),
    .held_byte  (held_byte)
  );

  wp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .held_valid (held_valid),
    .held_byte  (held_byte),
    .push_ready (push_ready),
    .push_valid (push_valid),
    .push_data  (push_data),
    .bus_ready  (bus_ready),
    .load_odd   (load_odd),
    .consume    (consume)
  );

  // R8: read data is all zeros
  assign bus_rdata = '0;

  // R1, R8: only write beats can produce entries
  a_r1_push_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (bus_valid && bus_write));

  // R4: an odd byte write never pushes on its own
  a_r4_odd_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_size == 2'd0 && bus_addr[0]) |-> !push_valid);

  // R5: an accepted even byte leaves nothing held
  a_r5_even_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && bus_size == 2'd0) |=> !held_valid);

  // R9: a refused entry is offered again unchanged while the beat is held
  a_r9_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && bus_size != 2'd2) |=> (push_valid && $stable(push_data)));

endmodule

// File: tb/tb_wr_pack_adapter.sv
`timescale 1ns/1ps
module tb_wr_pack_adapter;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_valid;
  logic              bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [31:0]       bus_wdata;
  logic              bus_ready;
  logic [31:0]       bus_rdata;
  logic              push_valid;
  logic [15:0]       push_data;
  logic              push_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural model state
  bit       m_hv;
  bit [7:0] m_hb;
  bit       m_ph;

  always #2 clk = ~clk;

  wr_pack_adapter #(.ADDR_W(ADDR_W), .WIN_LSB(11), .WIN_BASE('0)) dut (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_size,
    .bus_wdata, .bus_ready, .bus_rdata, .push_valid, .push_data, .push_ready
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: drive, compare, advance the model
  task automatic cycle(input bit v, input bit w, input logic [15:0] a,
                       input logic [1:0] sz, input logic [31:0] wd,
                       input bit fr, output bit acc);
    bit        e_push, e_rdy;
    bit [15:0] e_data;
    bit [7:0]  b;
    string     tag;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz;
    bus_wdata = wd; push_ready = fr;
    #1;
    e_push = 0; e_rdy = 1; e_data = '0; tag = "R10";
    if (v && !w) tag = "R8";
    else if (v && a[15:11] != 0) tag = "R1";
    else if (v) begin
      case (sz)
        2'd0: begin
          b = wd[8*a[1:0] +: 8];
          if (a[0]) begin
            tag = m_hv ? "R6" : "R4";
            m_hv = 1; m_hb = b;
          end else begin
            tag = m_hv ? "R5" : "R7";
            e_push = 1; e_rdy = fr;
            e_data = {m_hv ? m_hb : 8'h00, b};
            if (fr) m_hv = 0;
          end
        end
        2'd1: begin
          tag = m_hv ? "R11" : "R2";
          e_push = 1; e_rdy = fr; e_data = wd[16*a[1] +: 16];
        end
        2'd2: begin
          tag = "R3";
          e_push = 1;
          if (!m_ph) begin
            e_data = wd[15:0]; e_rdy = 0;
            if (fr) m_ph = 1;
          end else begin
            e_data = wd[31:16]; e_rdy = fr;
            if (fr) m_ph = 0;
          end
        end
        default: tag = "R12";
      endcase
    end
    if (e_push && !fr) tag = {tag, "/R9"};
    chk({tag, " bus_ready"}, {31'd0, bus_ready}, {31'd0, e_rdy});
    chk({tag, " push_valid"}, {31'd0, push_valid}, {31'd0, e_push});
    if (e_push) chk({tag, " push_data"}, {16'd0, push_data}, {16'd0, e_data});
    if (v && !w) chk("R8 rdata", bus_rdata, 32'd0);
    acc = v && e_rdy;
  endtask

  task automatic beat(input bit w, input logic [15:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input int stall_pct);
    bit acc;
    int n = 0;
    do begin
      cycle(1, w, a, sz, wd, ($urandom_range(0, 99) >= stall_pct) || n > 20, acc);
      n++;
    end while (!acc);
  endtask

  task automatic idle();
    bit acc;
    cycle(0, 0, '0, '0, '0, 1, acc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = '0;
    bus_size = '0; bus_wdata = '0; push_ready = 1;
    m_hv = 0; m_ph = 0;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 reset push_valid", {31'd0, push_valid}, 32'd0);
    chk("R10 reset bus_ready", {31'd0, bus_ready}, 32'd1);
    rst_n = 1;
  endtask

  initial begin
    bit acc;
    do_reset();
    idle();
    // R2 half-words on both lanes
    beat(1, 16'h0002, 2'd1, 32'hBEEF_1234, 0);
    beat(1, 16'h0000, 2'd1, 32'hBEEF_1234, 0);
    // R3 word, with and without back-pressure
    beat(1, 16'h0004, 2'd2, 32'hAAAA_5555, 0);
    beat(1, 16'h0008, 2'd2, 32'h1357_9BDF, 60);
    // R4 then R5 pairing
    beat(1, 16'h0001, 2'd0, 32'h0000_3400, 0);
    beat(1, 16'h0000, 2'd0, 32'h0000_0012, 0);
    // R6 overwrite of held byte
    beat(1, 16'h0001, 2'd0, 32'h0000_1100, 0);
    beat(1, 16'h0003, 2'd0, 32'h2200_0000, 0);
    beat(1, 16'h0002, 2'd0, 32'h0033_0000, 0);
    // R7 even byte alone
    beat(1, 16'h0000, 2'd0, 32'h0000_0044, 0);
    // R11 wider writes between the pair
    beat(1, 16'h0001, 2'd0, 32'h0000_5500, 0);
    beat(1, 16'h0002, 2'd1, 32'hCAFE_0000, 0);
    beat(1, 16'h0000, 2'd2, 32'hDEAD_F00D, 0);
    beat(1, 16'h0000, 2'd0, 32'h0000_0066, 0);
    // R8 read between the pair
    beat(1, 16'h0001, 2'd0, 32'h0000_7700, 0);
    beat(0, 16'h0000, 2'd2, 32'hFFFF_FFFF, 0);
    beat(1, 16'h0000, 2'd0, 32'h0000_0088, 0);
    // R1 outside the window, R12 reserved size
    beat(1, 16'h0801, 2'd0, 32'h0000_EE00, 0);
    beat(1, 16'h0800, 2'd1, 32'h0000_ABCD, 0);
    beat(1, 16'h0000, 2'd3, 32'h1234_5678, 0);
    beat(1, 16'h0000, 2'd0, 32'h0000_0001, 0);
    // R9 heavy back-pressure on even bytes and halves
    beat(1, 16'h0001, 2'd0, 32'h0000_4200, 80);
    beat(1, 16'h0000, 2'd0, 32'h0000_0024, 80);
    beat(1, 16'h0002, 2'd1, 32'h9876_0000, 80);
    // R10 reset drops the held byte
    beat(1, 16'h0001, 2'd0, 32'h0000_9900, 0);
    do_reset();
    beat(1, 16'h0000, 2'd0, 32'h0000_00AA, 0);
    // R10 reset mid-word restarts at the low half
    cycle(1, 1, 16'h0000, 2'd2, 32'h1111_2222, 1, acc);
    do_reset();
    beat(1, 16'h0000, 2'd2, 32'h3333_4444, 0);
    // mixed traffic
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] a;
      a = {4'd0, ($urandom_range(0, 9) == 0), 9'd0, 2'($urandom_range(0, 3))};
      beat($urandom_range(0, 5) != 0, a, 2'($urandom_range(0, 3)), $urandom, 30);
      if ($urandom_range(0, 3) == 0) idle();
    end
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule